// File: doc/BRIEF.md
# Adapter Setup and Global Enable Port Decoder

This block sits in the host I/O decode path of a display adapter. It watches every host I/O cycle (a 16-bit address with read and write strobes) and serves three small ports of its own. The first is a global control register that holds the adapter enable, a setup-mode flag and a 3-bit option ROM page number. Each page is 4 KB, so eight pages cover the ROM. The second is a sleep/wake port that holds the video-function enable and answers only while setup mode is on. The third is a write-only motherboard enable port.

The block also drives a per-cycle `io_respond` qualifier. The rest of the adapter's I/O decode uses it to decide whether a cycle may be answered. In normal operation any active cycle to a foreign address is allowed through. In setup mode every foreign address is held silent, and only the global control port and the sleep port answer. Reads of the global control port are claimed only while an external read-enable bit, held in another register block, is set.

Top module: `adapter_port_decode`

## Requirements
- R1: After reset the outputs are `adapter_en`=1, `setup_mode`=0, `rom_page`=0, `video_en`=1 and `mb_en`=1.
- R2: A write to the global control port updates the registers on the next clock edge: data bits [2:0] go to `rom_page`, bit 3 goes to `adapter_en` and bit 4 goes to `setup_mode`. Bits 7:5 are ignored. The write is claimed in both modes.
- R3: A read of the global control port is claimed only when `rd_en_ext`=1. It returns {3'b000, setup_mode, adapter_en, rom_page}. With `rd_en_ext`=0 the read gives `io_respond`=0 and `io_rdata`=0.
- R4: While setup mode is on, the sleep port at 0x0102 is claimed for reads and writes. A write stores data bit 0 into `video_en`. A read returns {7'b0, video_en}, so the reserved bits read as 0.
- R5: While setup mode is off, the sleep port is not claimed. A write to it leaves `video_en` unchanged, and `io_respond` is 0.
- R6: A write to port 0x03C3 is claimed only outside setup mode. It loads data bit 0 into `mb_en`. Reads of 0x03C3 are never claimed. Writes made during setup mode leave `mb_en` unchanged.
- R7: For an active cycle (read or write strobe high) to any address the block does not own, `io_respond` is 1 outside setup mode and 0 in setup mode. With no strobe, `io_respond` is 0.
- R8: `io_rdata` is 0 in every cycle that is not a claimed read.
- R9: The global control port decodes at exactly 0x46E8, 0x56E8, 0x66E8 and 0x76E8: address bits [15:14]=2'b01, bits [13:12] don't care, and bits [11:0]=0x6E8. Any other address, such as 0x06E8, 0x86E8 or 0x46E9, neither changes the registers nor is treated as the control port.
- R10: `io_respond` and `io_rdata` are combinational and use the mode held before the current clock edge. A write that enters or leaves setup mode affects the qualifier from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| rd_en_ext | input | 1 | External enable for reads of the global control port |
| io_rdata | output | 8 | Read data, 0 unless a claimed read |
| io_respond | output | 1 | Cycle may be answered (own claim, or foreign port outside setup) |
| adapter_en | output | 1 | Adapter enable |
| setup_mode | output | 1 | Setup mode active |
| rom_page | output | 3 | Option ROM page select |
| video_en | output | 1 | Video function enable from the sleep port |
| mb_en | output | 1 | Motherboard enable bit |

## Verification
A setup-mode change and the qualification of the cycle that causes it happen together. A global control write that sets or clears bit 4 is also an I/O cycle, and its own `io_respond` must follow the old mode. The next cycle must follow the new one. The bench provokes this by sweeping all 256 write values over the four aliases. After each write it probes the sleep port, port 0x03C3 and a foreign address. Every cycle is judged against a model that uses the mode held before the edge.

// File: rtl/adapter_port_decode.sv
module adapter_port_decode #(
  parameter logic [15:0] SLEEP_PORT = 16'h0102,
  parameter logic [15:0] MB_PORT    = 16'h03C3,
  parameter logic [11:0] GLB_LOW    = 12'h6E8,
  parameter logic [1:0]  GLB_TOP    = 2'b01,
  parameter int          PAGE_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  input  logic              rd_en_ext,
  output logic [7:0]        io_rdata,
  output logic              io_respond,
  output logic              adapter_en,
  output logic              setup_mode,
  output logic [PAGE_W-1:0] rom_page,
  output logic              video_en,
  output logic              mb_en
);

  localparam int EN_BIT = PAGE_W;
  localparam int SU_BIT = PAGE_W + 1;
  localparam int REG_W  = PAGE_W + 2;

  logic [PAGE_W-1:0] page_q;
  logic              en_q, setup_q, video_q, mb_q;

  wire active  = io_rd | io_wr;
  wire hit_glb = (io_addr[15:14] == GLB_TOP) && (io_addr[11:0] == GLB_LOW);
  wire hit_slp = (io_addr == SLEEP_PORT);
  wire hit_mb  = (io_addr == MB_PORT);
  wire owned   = hit_glb | hit_slp | hit_mb;

  wire glb_rd  = io_rd & hit_glb & rd_en_ext;
  wire glb_wr  = io_wr & hit_glb;
  wire slp_rd  = io_rd & hit_slp & setup_q;
  wire slp_wr  = io_wr & hit_slp & setup_q;
  wire mb_wr   = io_wr & hit_mb & ~setup_q;
  wire claimed = glb_rd | glb_wr | slp_rd | slp_wr | mb_wr;

  assign io_respond = claimed | (active & ~owned & ~setup_q);

  always_comb begin
    io_rdata = '0;
    if (glb_rd)      io_rdata = 8'({setup_q, en_q, page_q});
    else if (slp_rd) io_rdata = {7'b0, video_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      en_q    <= 1'b1;
      setup_q <= 1'b0;
      video_q <= 1'b1;
      mb_q    <= 1'b1;
    end else begin
      if (glb_wr) begin
        page_q  <= io_wdata[PAGE_W-1:0];
        en_q    <= io_wdata[EN_BIT];
        setup_q <= io_wdata[SU_BIT];
      end
      if (slp_wr) video_q <= io_wdata[0];
      if (mb_wr)  mb_q    <= io_wdata[0];
    end
  end

  assign adapter_en = en_q;
  assign setup_mode = setup_q;
  assign rom_page   = page_q;
  assign video_en   = video_q;
  assign mb_en      = mb_q;

  p_glb_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit_glb) |=> (rom_page == $past(io_wdata[PAGE_W-1:0]) &&
                            adapter_en == $past(io_wdata[EN_BIT]) &&
                            setup_mode == $past(io_wdata[SU_BIT])));

  p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_mode |=> $stable(video_en));

  p_mb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    setup_mode |=> $stable(mb_en));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_mode && !owned) |-> !io_respond);

  p_rdata_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_respond |-> (io_rdata == 8'h00));

  p_reg_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[7:REG_W] == '0);

endmodule

// File: tb/test_adapter_port_decode.sv
module test_adapter_port_decode;
  logic clk = 0, rst_n = 0;
  logic [15:0] io_addr = 0;
  logic io_rd = 0, io_wr = 0, rd_en_ext = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic io_respond, adapter_en, setup_mode, video_en, mb_en;
  logic [2:0] rom_page;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [2:0] m_page; logic m_en, m_setup, m_video, m_mb;

  always #4 clk = ~clk;

  adapter_port_decode i_adapter_port_decode (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .rd_en_ext(rd_en_ext), .io_rdata(io_rdata),
    .io_respond(io_respond), .adapter_en(adapter_en), .setup_mode(setup_mode),
    .rom_page(rom_page), .video_en(video_en), .mb_en(mb_en));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_glb(input logic [15:0] a);
    return (a == 16'h46E8) || (a == 16'h56E8) || (a == 16'h66E8) || (a == 16'h76E8);
  endfunction

  task automatic check_state(input string tag);
    chk("R2", {tag, " rom_page"}, rom_page, m_page);
    chk("R2", {tag, " adapter_en"}, adapter_en, m_en);
    chk("R2", {tag, " setup_mode"}, setup_mode, m_setup);
    chk("R4", {tag, " video_en"}, video_en, m_video);
    chk("R6", {tag, " mb_en"}, mb_en, m_mb);
  endtask

  task automatic cyc(input logic [15:0] a, input bit rd, input bit wr, input logic [7:0] d, input bit ext);
    bit g, s, m, own, clm, exp_resp;
    logic [7:0] exp_rd;
    string req;
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d; rd_en_ext = ext;
    #1;
    g = is_glb(a); s = (a == 16'h0102); m = (a == 16'h03C3);
    own = g | s | m;
    clm = (g & (wr | (rd & ext))) | (s & m_setup & (rd | wr)) | (m & wr & !m_setup);
    exp_resp = clm | ((rd | wr) & !own & !m_setup);
    exp_rd = 8'h00;
    if (rd & g & ext) exp_rd = {3'b000, m_setup, m_en, m_page};
    else if (rd & s & m_setup) exp_rd = {7'b0, m_video};
    if (g) req = rd ? "R3" : "R2";
    else if (s) req = m_setup ? "R4" : "R5";
    else if (m) req = "R6";
    else if (a[11:0] == 12'h6E8 || a == 16'h46E9) req = "R9";
    else req = "R7";
    chk(req, "io_respond (R10 old mode)", io_respond, exp_resp);
    chk(exp_rd == 0 ? "R8" : req, "io_rdata", io_rdata, exp_rd);
    if (g & wr) begin m_page = d[2:0]; m_en = d[3]; m_setup_next(d[4]); end
    else if (s & wr & m_setup) m_video = d[0];
    else if (m & wr & !m_setup) m_mb = d[0];
    @(negedge clk);
    io_rd = 0; io_wr = 0;
    #1;
    check_state(req);
  endtask

  task automatic m_setup_next(input bit v); m_setup = v; endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    m_page = 0; m_en = 1; m_setup = 0; m_video = 1; m_mb = 1;
    chk("R1", "reset rom_page", rom_page, 0);
    chk("R1", "reset adapter_en", adapter_en, 1);
    chk("R1", "reset setup_mode", setup_mode, 0);
    chk("R1", "reset video_en", video_en, 1);
    chk("R1", "reset mb_en", mb_en, 1);
    chk("R7", "idle io_respond", io_respond, 0);

    cyc(16'h0102, 0, 1, 8'h00, 0);
    cyc(16'h0102, 1, 0, 8'h00, 0);
    cyc(16'h03C3, 1, 0, 8'h00, 0);
    cyc(16'h03D4, 1, 0, 8'h00, 0);

    for (int hi = 0; hi < 16; hi++) begin
      cyc({hi[3:0], 12'h6E8}, 0, 1, {4'b0, 4'(hi) ^ 4'h5}, 0);
      cyc({hi[3:0], 12'h6E9}, 0, 1, 8'h07, 0);
      cyc({hi[3:0], 12'h6E8}, 1, 0, 8'h00, 1);
    end

    for (int d = 0; d < 256; d++) begin
      logic [15:0] ga;
      ga = {2'b01, 2'(d), 12'h6E8};
      cyc(ga, 0, 1, 8'(d), 0);
      cyc(16'h46E8, 1, 0, 8'h00, 1);
      cyc(16'h76E8, 1, 0, 8'h00, 0);
      cyc(16'h0102, 0, 1, 8'(d >> 3) ^ 8'hFE, 0);
      cyc(16'h0102, 1, 0, 8'h00, 0);
      cyc(16'h03C3, 0, 1, 8'(d >> 1), 0);
      cyc(16'h03C3, 1, 0, 8'h00, 0);
      cyc(16'h03D4, d[0], !d[0], 8'hAA, 1);
      cyc(16'h06E8, 0, 1, 8'h1F, 0);
    end

    cyc(16'h46E8, 0, 1, 8'h10, 0);
    cyc(16'h03CE, 1, 0, 8'h00, 0);
    cyc(16'h46E8, 0, 1, 8'h08, 0);
    cyc(16'h03CE, 1, 0, 8'h00, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule